// File: doc/BRIEF.md
# ADC Conversion Sequencer With Register Front End

This block sits between a byte-wide register bus and a 10-bit successive-approximation converter core. Software writes one control byte that holds a timing code, a reference choice and an input channel. That write also launches a conversion. The sequencer then runs a sample phase and a conversion phase. Both are counted in clock periods, and their lengths come from the timing code. On the last clock of the conversion phase the block latches the 10-bit word presented by the converter core and raises its completion flag.

The result is read as two bytes. The upper byte holds the eight most significant bits. The lower control address returns the completion flag together with the two least significant bits. The block drives the channel select, reference select, buffer enable and sample strobe lines toward the analog side. A module-enable input holds the whole sequencer quiet while it is low.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the completion flag reads 1. chan_sel, ref_sel, buf_en, samp_strobe and the stored result are all 0.
- R2: A write to address 0 loads three fields. Bits 7:6 are the timing code, bits 5:4 are ref_sel and bits 3:0 are chan_sel. In chan_sel, bit 3 picks the port (0 or 1) and bits 2:0 pick the pin. ref_sel codes are 0 = main external, 1 = internal, 2 = external 0 and 3 = external 1. chan_sel holds steady during a sample phase unless a new start arrives.
- R3: samp_strobe goes high on the cycle after an address-0 write. It stays high for 20, 60, 140 or 300 clock cycles for timing codes 0, 1, 2 and 3.
- R4: The conversion phase follows at once and lasts 40, 80, 160 or 320 cycles for codes 0 to 3. On its final clock, conv_in is latched and the flag becomes 1. The flag first reads 1 exactly sample + conversion cycles after the write edge.
- R5: Reading address 1 returns result bits 9:2. Reading address 0 returns the flag in bit 7, zeros in bits 6:2 and result bits 1:0 in bits 1:0.
- R6: The stored result does not change while the flag is 1 and no new conversion is started, whatever conv_in does.
- R7: An address-0 write during a running conversion abandons it. The sample phase restarts with the new settings, and nothing is latched from the abandoned run.
- R8: A write to address 1 sets buf_en to wr_data bit 0 (1 = input buffer used, 0 = bypassed). It does not start a conversion.
- R9: While mod_en is low, the sequencer stays idle, samp_strobe is 0, the flag reads 1 and writes are ignored. Dropping mod_en during a run ends that run.
- R10: Every address-0 write made while enabled clears the flag on the same edge that starts the sample phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en | input | 1 | Module enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 = control/start, 1 = buffer) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address (0 = flag and low bits, 1 = high bits) |
| rd_data | output | 8 | Read data, combinational |
| conv_in | input | 10 | Digital word from the converter core |
| chan_sel | output | 4 | Input multiplexer selection |
| ref_sel | output | 2 | Reference selection |
| buf_en | output | 1 | Input buffer enable |
| samp_strobe | output | 1 | High for the whole sample phase |

## Verification
Every timing code is combined with every channel, with ref_sel cycled alongside. Counting the strobe cycles and the flag latency separates all four sample lengths from all four conversion lengths, and catches off-by-one counts. conv_in holds a wrong word until the clock just before the expected capture, so a capture that comes one cycle early returns the wrong value. Full-scale and zero inputs are included, and conv_in changes after capture to show that the result holds. Restarts during the sample phase and during the conversion phase are also applied, together with writes and runs while the module is disabled.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_CONV   = 2'd2
   } phase_e;

   // sample phase grows as unit * (2^(code+1) - 1)
   function automatic int unsigned samp_len(input logic [1:0] code, input int unsigned unit);
      return unit * ((32'd2 << code) - 32'd1);
   endfunction

   // conversion phase doubles per code step
   function automatic int unsigned conv_len(input logic [1:0] code, input int unsigned unit);
      return unit << code;
   endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs #(
   parameter int CHAN_W = 4,
   parameter int REF_W  = 2,
   parameter int TC_W   = 2,
   localparam int DATA_W = TC_W + REF_W + CHAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_en,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              start,
   output logic [TC_W-1:0]   start_tcode,
   output logic [TC_W-1:0]   tcode,
   output logic [REF_W-1:0]  ref_sel,
   output logic [CHAN_W-1:0] chan_sel,
   output logic              buf_en
);

   logic wr_ctrl;
   logic wr_buf;

   assign wr_ctrl     = mod_en & wr_en & ~wr_addr;
   assign wr_buf      = mod_en & wr_en &  wr_addr;
   assign start       = wr_ctrl;
   assign start_tcode = wr_data[DATA_W-1 -: TC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcode    <= '0;
         ref_sel  <= '0;
         chan_sel <= '0;
      end else if (wr_ctrl) begin
         tcode    <= wr_data[DATA_W-1 -: TC_W];
         ref_sel  <= wr_data[CHAN_W +: REF_W];
         chan_sel <= wr_data[CHAN_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         buf_en <= 1'b0;
      else if (wr_buf)
         buf_en <= wr_data[0];
   end

endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer
   import adc_seq_pkg::*;
#(
   parameter int unsigned SAMP_UNIT = 20,
   parameter int unsigned CONV_UNIT = 40,
   parameter int CNT_W = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mod_en,
   input  logic       start,
   input  logic [1:0] start_tcode,
   input  logic [1:0] run_tcode,
   output phase_e     phase,
   output logic       capture
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] samp_load;
   logic [CNT_W-1:0] conv_load;
   logic             cnt_zero;

   assign samp_load = CNT_W'(samp_len(start_tcode, SAMP_UNIT) - 1);
   assign conv_load = CNT_W'(conv_len(run_tcode, CONV_UNIT) - 1);
   assign cnt_zero  = (cnt_q == '0);
   assign capture   = (phase == PH_CONV) && cnt_zero && mod_en && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt_q <= '0;
      end else if (!mod_en) begin
         phase <= PH_IDLE;
         cnt_q <= '0;
      end else if (start) begin
         phase <= PH_SAMPLE;
         cnt_q <= samp_load;
      end else begin
         unique case (phase)
            PH_SAMPLE: begin
               if (cnt_zero) begin
                  phase <= PH_CONV;
                  cnt_q <= conv_load;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_CONV: begin
               if (cnt_zero)
                  phase <= PH_IDLE;
               else
                  cnt_q <= cnt_q - 1'b1;
            end
            default: begin
               phase <= PH_IDLE;
               cnt_q <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/adc_result_cap.sv
module adc_result_cap #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_en,
   input  logic             start,
   input  logic             capture,
   input  logic [RES_W-1:0] conv_in,
   output logic [RES_W-1:0] result,
   output logic             done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         done   <= 1'b1;
      end else if (!mod_en) begin
         done   <= 1'b1;
      end else if (start) begin
         done   <= 1'b0;
      end else if (capture) begin
         result <= conv_in;
         done   <= 1'b1;
      end
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int CHAN_W = 4,
   parameter int REF_W  = 2,
   parameter int RES_W  = 10,
   parameter int unsigned SAMP_UNIT = 20,
   parameter int unsigned CONV_UNIT = 40,
   localparam int TC_W   = 2,
   localparam int DATA_W = TC_W + REF_W + CHAN_W,
   localparam int LSB_W  = RES_W - DATA_W,
   localparam int PAD_W  = DATA_W - 1 - LSB_W,
   localparam int MAX_LEN = (SAMP_UNIT * 15 > CONV_UNIT * 8) ? SAMP_UNIT * 15 : CONV_UNIT * 8,
   localparam int CNT_W  = $clog2(MAX_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_en,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [RES_W-1:0]  conv_in,
   output logic [CHAN_W-1:0] chan_sel,
   output logic [REF_W-1:0]  ref_sel,
   output logic              buf_en,
   output logic              samp_strobe
);

   generate
      if (LSB_W < 1 || PAD_W < 0) begin : g_bad_split
         $error("RES_W must exceed DATA_W and its low part must fit beside the flag");
      end
      if (SAMP_UNIT < 1 || CONV_UNIT < 1) begin : g_bad_unit
         $error("phase units must be at least one clock");
      end
   endgenerate

   logic             start;
   logic [TC_W-1:0]  start_tcode;
   logic [TC_W-1:0]  run_tcode;
   phase_e           phase;
   logic             capture;
   logic [RES_W-1:0] result_q;
   logic             done_q;
   logic [DATA_W-1:0] low_word;

   adc_cfg_regs #(
      .CHAN_W (CHAN_W),
      .REF_W  (REF_W),
      .TC_W   (TC_W)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .mod_en      (mod_en),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .start       (start),
      .start_tcode (start_tcode),
      .tcode       (run_tcode),
      .ref_sel     (ref_sel),
      .chan_sel    (chan_sel),
      .buf_en      (buf_en)
   );

   adc_phase_timer #(
      .SAMP_UNIT (SAMP_UNIT),
      .CONV_UNIT (CONV_UNIT),
      .CNT_W     (CNT_W)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .mod_en      (mod_en),
      .start       (start),
      .start_tcode (start_tcode),
      .run_tcode   (run_tcode),
      .phase       (phase),
      .capture     (capture)
   );

   adc_result_cap #(
      .RES_W (RES_W)
   ) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .mod_en  (mod_en),
      .start   (start),
      .capture (capture),
      .conv_in (conv_in),
      .result  (result_q),
      .done    (done_q)
   );

   assign samp_strobe = (phase == PH_SAMPLE);

   generate
      if (PAD_W > 0) begin : g_low_pad
         assign low_word = {done_q, {PAD_W{1'b0}}, result_q[LSB_W-1:0]};
      end else begin : g_low_nopad
         assign low_word = {done_q, result_q[LSB_W-1:0]};
      end
   endgenerate

   assign rd_data = rd_addr ? result_q[RES_W-1 -: DATA_W] : low_word;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
   import adc_seq_pkg::*;
#(
   parameter int CHAN_W = 4,
   parameter int RES_W  = 10,
   parameter int unsigned SAMP_UNIT = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mod_en,
   input logic              wr_en,
   input logic              wr_addr,
   input logic              wr_bit0,
   input logic [RES_W-1:0]  conv_in,
   input logic [CHAN_W-1:0] chan_sel,
   input logic              buf_en,
   input logic              samp_strobe,
   input logic              done,
   input logic [RES_W-1:0]  result
);

   logic        start_w;
   logic [15:0] run_q;

   assign start_w = mod_en & wr_en & ~wr_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (start_w)
         run_q <= '0;
      else if (samp_strobe)
         run_q <= run_q + 16'd1;
      else
         run_q <= '0;
   end

   assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> (!done && samp_strobe));

   assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_en |=> (done && !samp_strobe));

   assert_capture_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && $past(mod_en)) |-> (result == $past(conv_in)));

   assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start_w) |=> $stable(result));

   assert_chan_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_strobe && !start_w) |=> $stable(chan_sel));

   assert_buf_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_en && wr_en && wr_addr) |=> (buf_en == $past(wr_bit0)));

   assert_samp_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(samp_strobe) && $past(mod_en) && !$past(start_w)) |->
         (run_q == 16'(samp_len(2'd0, SAMP_UNIT)) || run_q == 16'(samp_len(2'd1, SAMP_UNIT)) ||
          run_q == 16'(samp_len(2'd2, SAMP_UNIT)) || run_q == 16'(samp_len(2'd3, SAMP_UNIT))));

endmodule

bind adc_seq_ctrl adc_seq_chk #(
   .CHAN_W    (CHAN_W),
   .RES_W     (RES_W),
   .SAMP_UNIT (SAMP_UNIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mod_en      (mod_en),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_bit0     (wr_data[0]),
   .conv_in     (conv_in),
   .chan_sel    (chan_sel),
   .buf_en      (buf_en),
   .samp_strobe (samp_strobe),
   .done        (done_q),
   .result      (result_q)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mod_en = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_addr = 1'b0;
   logic [7:0] rd_data;
   logic [9:0] conv_in = '0;
   logic [3:0] chan_sel;
   logic [1:0] ref_sel;
   logic       buf_en;
   logic       samp_strobe;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   adc_seq_ctrl u_adc_seq_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .mod_en      (mod_en),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .conv_in     (conv_in),
      .chan_sel    (chan_sel),
      .ref_sel     (ref_sel),
      .buf_en      (buf_en),
      .samp_strobe (samp_strobe)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   // drive at a falling edge, commit on the next rising edge, return at the falling edge after it
   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic int exp_samp(input int c);
      case (c)
         0: return 20;
         1: return 60;
         2: return 140;
         default: return 300;
      endcase
   endfunction

   function automatic int exp_conv(input int c);
      case (c)
         0: return 40;
         1: return 80;
         2: return 160;
         default: return 320;
      endcase
   endfunction

   task automatic run_conv(input int code, input int rsel, input int ch, input logic [9:0] val);
      int s, c, idx, strobes, done_at;
      logic [7:0] v;
      s = exp_samp(code);
      c = exp_conv(code);
      conv_in = val ^ 10'h2A5;
      wr(1'b0, {code[1:0], rsel[1:0], ch[3:0]});
      rd(1'b0, v);
      chk("R10 flag cleared by start", int'(v[7]), 0);
      chk("R2 chan_sel", int'(chan_sel), ch);
      chk("R2 ref_sel", int'(ref_sel), rsel);
      strobes = 0;
      done_at = -1;
      for (idx = 0; idx < 2000; idx++) begin
         rd(1'b0, v);
         if (samp_strobe) strobes++;
         if (v[7]) begin
            done_at = idx;
            break;
         end
         if (idx == s + c - 1) conv_in = val;
         @(negedge clk);
      end
      chk("R3 sample cycles", strobes, s);
      chk("R4 flag latency", done_at, s + c);
      rd(1'b1, v);
      chk("R5 high byte", int'(v), int'(val[9:2]));
      rd(1'b0, v);
      chk("R5 low byte", int'(v), int'({1'b1, 5'b0, val[1:0]}));
      conv_in = ~val;
      repeat (3) @(negedge clk);
      rd(1'b1, v);
      chk("R6 high byte held", int'(v), int'(val[9:2]));
      rd(1'b0, v);
      chk("R6 low bits held", int'(v[1:0]), int'(val[1:0]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R4 watchdog expired: actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [3:0] ch_keep;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(1'b0, v);
      chk("R1 flag after reset", int'(v[7]), 1);
      chk("R1 low bits after reset", int'(v[1:0]), 0);
      rd(1'b1, v);
      chk("R1 high byte after reset", int'(v), 0);
      chk("R1 chan_sel", int'(chan_sel), 0);
      chk("R1 ref_sel", int'(ref_sel), 0);
      chk("R1 buf_en", int'(buf_en), 0);
      chk("R1 strobe", int'(samp_strobe), 0);

      mod_en = 1'b1;
      @(negedge clk);
      rd(1'b0, v);
      chk("R9 flag after enable", int'(v[7]), 1);

      // sweep all timing codes against all channels
      for (int code = 0; code < 4; code++) begin
         for (int ch = 0; ch < 16; ch++) begin
            logic [9:0] val;
            if (ch == 0) val = 10'h3FF;
            else if (ch == 15) val = 10'h000;
            else val = 10'((code * 16 + ch) * 37 + 5);
            run_conv(code, (ch + code) % 4, ch, val);
         end
      end

      // buffer control
      wr(1'b1, 8'h01);
      chk("R8 buf_en set", int'(buf_en), 1);
      rd(1'b0, v);
      chk("R8 no start flag", int'(v[7]), 1);
      chk("R8 no start strobe", int'(samp_strobe), 0);
      wr(1'b1, 8'hFE);
      chk("R8 buf_en clear", int'(buf_en), 0);

      // restart during conversion phase
      wr(1'b0, {2'd0, 2'd1, 4'd3});
      repeat (30) @(negedge clk);
      run_conv(1, 2, 9, 10'h1C7);
      // restart during sample phase
      wr(1'b0, {2'd3, 2'd0, 4'd12});
      repeat (5) @(negedge clk);
      run_conv(0, 3, 6, 10'h2B4);
      chk("R7 settings replaced", int'(chan_sel), 6);

      // disable mid-run
      wr(1'b0, {2'd1, 2'd1, 4'd10});
      repeat (4) @(negedge clk);
      mod_en = 1'b0;
      @(negedge clk);
      rd(1'b0, v);
      chk("R9 flag when disabled", int'(v[7]), 1);
      chk("R9 strobe when disabled", int'(samp_strobe), 0);
      ch_keep = chan_sel;
      wr(1'b0, {2'd2, 2'd3, 4'd15});
      chk("R9 write ignored chan", int'(chan_sel), int'(ch_keep));
      rd(1'b0, v);
      chk("R9 write ignored flag", int'(v[7]), 1);
      chk("R9 write ignored strobe", int'(samp_strobe), 0);
      rd(1'b1, v);
      chk("R9 result untouched", int'(v), int'(8'({10'h2B4} >> 2)));
      mod_en = 1'b1;
      @(negedge clk);
      rd(1'b0, v);
      chk("R9 flag after re-enable", int'(v[7]), 1);
      run_conv(2, 1, 13, 10'h155);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule